// File: doc/BRIEF.md
# Serial-Loaded Double-Buffered DAC Code Register

This block is the digital front end of a 16-bit segmented voltage DAC. A host writes a code over a three-wire serial link: an active-low select frames the word, and each rising edge of the serial clock moves one data bit, most significant first, into a serial holding register. A second register, the DAC register, holds the code that actually drives the converter. Because there are two registers, a new code can be preloaded without disturbing the present output. It is moved across either at the end of the frame, when the load strobe is already low, or later by a falling edge on the load strobe.

An active-low clear input empties both registers on its falling edge and blocks every transfer while it stays low. The DAC register output is presented three ways: as the raw code, as a 15-wide thermometer vector decoded from the top four bits, and as the 12-bit word for the binary ladder. All serial pins are brought into the system clock through two-flop synchronizers, and edges are detected there. An input change therefore shows on the outputs after the third rising system-clock edge that follows it. The serial clock must run at no more than a quarter of the system clock.

Top module: `serdac_frontend`

## Requirements
- R1: After the power-on reset `rst_n` is released, `dac_code`, `seg_en` and `ladder` are all zero.
- R2: While `sel_n` is low, each rising edge of `sclk` shifts `sdi` into bit 0 of the serial register and moves every older bit up one place. The first bit of a 16-bit frame therefore ends in bit 15.
- R3: A rising edge of `sel_n` while `load_n` is low and `clr_n` is high copies the serial register into the DAC register. The outputs take the new value at the third rising `clk` edge after the `sel_n` change.
- R4: A rising edge of `sel_n` while `load_n` is high leaves the DAC register unchanged, and the frame's data stays in the serial register.
- R5: A falling edge of `load_n` while `clr_n` is high copies the serial register into the DAC register, with no `sclk` activity needed.
- R6: When a frame holds more than 16 bits, the last 16 are kept. When a frame holds n < 16 bits, the serial register becomes {old[15-n:0], the n new bits}.
- R7: Rising `sclk` edges while `sel_n` is high do not change the serial register.
- R8: A falling edge of `clr_n` sets both the DAC register and the serial register to zero.
- R9: While `clr_n` is low, neither a falling `load_n` edge nor a `sel_n` rising edge with `load_n` low changes the DAC register.
- R10: With k the value of `dac_code[15:12]`, `seg_en` bits 0 to k-1 are one and all higher bits are zero. Bit i stands for segment i+1, and k = 0 gives no enabled segments.
- R11: `dac_code` equals the DAC register, and `ladder` equals `dac_code[11:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| sel_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial bit clock, sampled on its rising edge |
| sdi | input | 1 | Serial data, most significant bit first |
| load_n | input | 1 | Active-low load strobe for the DAC register |
| clr_n | input | 1 | Active-low clear; the falling edge clears, the low level masks loads |
| dac_code | output | 16 | Present DAC register contents |
| seg_en | output | 15 | Thermometer enables from the top four code bits |
| ladder | output | 12 | Low twelve code bits for the binary ladder |

## Verification
The bench compares its own model of the DAC register against the outputs on every clock and places each expected change on the exact cycle. A design that updated early, late, or without the load condition is therefore caught at once. It sends over-long and short frames: a register that kept the first 16 bits, or cleared the unshifted part, would show a wrong code. It clocks `sclk` with select high, and a design that shifted anyway would corrupt the next load-strobe transfer. It pulses the load strobe and ends frames while clear is held low, then releases clear and transfers again. This exposes designs that let loads through the mask, that leave the serial register intact after a clear, or that wipe it during the mask. A sweep of all sixteen upper-nibble values checks that each one lights exactly that many thermometer enables.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int DEF_DATA_W   = 16;
  localparam int DEF_SEG_BITS = 4;
  localparam int DEF_SYNC     = 2;

  // Events decoded from the synchronized pins, one cycle wide each
  typedef struct packed {
    logic shift;  // accepted serial bit
    logic xfer;   // serial -> DAC register copy
    logic clr;    // clear falling edge
  } fe_evt_t;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dacfe_shift.sv
module dacfe_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              clr,
  input  logic              din,
  output logic [DATA_W-1:0] q
);
  // Holding register has no power-on reset: its start value is undefined
  always_ff @(posedge clk) begin
    if (clr)           q <= '0;
    else if (shift_en) q <= {q[DATA_W-2:0], din};
  end

  assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr) |=> (q == {$past(q[DATA_W-2:0]), $past(din)}));

  assert_shift_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clr) |=> $stable(q));

  assert_shift_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
endmodule

// File: rtl/dacfe_dacreg.sv
module dacfe_dacreg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (clr)  q <= '0;
    else if (load) q <= d;
  end

  assert_dac_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (q == $past(d)));

  assert_dac_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr) |=> $stable(q));

  assert_dac_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
endmodule

// File: rtl/dacfe_segdec.sv
module dacfe_segdec #(
  parameter int DATA_W = 16,
  parameter int SEG_BITS = 4,
  localparam int SEG_N = (1 << SEG_BITS) - 1,
  localparam int LAD_W = DATA_W - SEG_BITS
) (
  input  logic [DATA_W-1:0] code,
  output logic [SEG_N-1:0]  seg_en,
  output logic [LAD_W-1:0]  ladder
);
  logic [SEG_BITS-1:0] top_val;
  assign top_val = code[DATA_W-1 -: SEG_BITS];
  assign ladder  = code[LAD_W-1:0];

  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    localparam logic [SEG_BITS-1:0] IDX = SEG_BITS'(i);
    assign seg_en[i] = (top_val > IDX);
  end

  always_comb begin
    assert_seg_count_R10: assert ($countones(seg_en) == int'(top_val));
    assert_seg_shape_R10: assert ((seg_en & (seg_en + SEG_N'(1))) == '0);
  end
endmodule

// File: rtl/serdac_frontend.sv
module serdac_frontend #(
  parameter int DATA_W = dacfe_pkg::DEF_DATA_W,
  parameter int SEG_BITS = dacfe_pkg::DEF_SEG_BITS,
  parameter int SYNC_STAGES = dacfe_pkg::DEF_SYNC
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel_n,
  input  logic                          sclk,
  input  logic                          sdi,
  input  logic                          load_n,
  input  logic                          clr_n,
  output logic [DATA_W-1:0]             dac_code,
  output logic [(1 << SEG_BITS)-2:0]    seg_en,
  output logic [DATA_W-SEG_BITS-1:0]    ladder
);
  import dacfe_pkg::*;

  // pin vector order: {clr_n, load_n, sdi, sclk, sel_n}
  localparam logic [4:0] PIN_IDLE  = 5'b11001;
  localparam logic [3:0] PREV_IDLE = 4'b1101;  // {clr, load, sclk, sel}

  logic [4:0] pins_s;
  logic [3:0] prev_s;
  logic [DATA_W-1:0] sh_word;
  fe_evt_t evt;

  dacfe_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({clr_n, load_n, sdi, sclk, sel_n}), .q(pins_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_s <= PREV_IDLE;
    else        prev_s <= {pins_s[4], pins_s[3], pins_s[1], pins_s[0]};
  end

  // named internal events
  logic cs_low, sclk_rise, cs_rise, ld_fall, clr_fall, clr_low, ld_low, sdi_s;
  assign cs_low    = ~pins_s[0];
  assign sclk_rise = pins_s[1] & ~prev_s[1];
  assign cs_rise   = pins_s[0] & ~prev_s[0];
  assign ld_low    = ~pins_s[3];
  assign ld_fall   = ~pins_s[3] & prev_s[2];
  assign clr_low   = ~pins_s[4];
  assign clr_fall  = ~pins_s[4] & prev_s[3];
  assign sdi_s     = pins_s[2];

  assign evt.shift = sclk_rise & cs_low;
  assign evt.clr   = clr_fall;
  assign evt.xfer  = ~clr_low & ((cs_rise & ld_low) | ld_fall);

  dacfe_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(evt.shift), .clr(evt.clr),
    .din(sdi_s), .q(sh_word));

  dacfe_dacreg #(.DATA_W(DATA_W)) u_dacreg (
    .clk(clk), .rst_n(rst_n), .clr(evt.clr), .load(evt.xfer),
    .d(sh_word), .q(dac_code));

  dacfe_segdec #(.DATA_W(DATA_W), .SEG_BITS(SEG_BITS)) u_segdec (
    .code(dac_code), .seg_en(seg_en), .ladder(ladder));

  assert_cs_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !cs_low && !clr_fall) |=> $stable(sh_word));

  assert_clr_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_low && !clr_fall) |=> $stable(dac_code));

  assert_end_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && ld_low && !clr_low) |=> (dac_code == $past(sh_word)));
endmodule

// File: tb/serdac_frontend_tb.sv
module serdac_frontend_tb_top;
  logic clk = 1'b0;
  logic rst_n, sel_n, sclk, sdi, load_n, clr_n;
  logic [15:0] dac_code;
  logic [14:0] seg_en;
  logic [11:0] ladder;

  always #10 clk = ~clk;  // 50 MHz

  serdac_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .load_n(load_n), .clr_n(clr_n), .dac_code(dac_code), .seg_en(seg_en),
    .ladder(ladder));

  localparam int LAT = 3;  // two synchronizer flops plus the register

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [15:0] m_sh = '0, m_dac = '0, pend_val = '0;
  bit pend = 0;
  int pend_due = 0;
  string tag = "R1";

  always @(posedge clk) cyc++;

  function automatic logic [14:0] exp_seg(input int k);
    return 15'((32'd1 << k) - 1);
  endfunction

  // per-clock comparison with the model
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (pend && cyc >= pend_due) begin m_dac = pend_val; pend = 0; end
      n_chk++;
      if (dac_code !== m_dac || ladder !== m_dac[11:0] ||
          seg_en !== exp_seg(int'(m_dac[15:12]))) begin
        n_fail++;
        $display("FAIL %s cycle %0d: code=%h seg=%h lad=%h expected code=%h seg=%h",
                 tag, cyc, dac_code, seg_en, ladder, m_dac, exp_seg(int'(m_dac[15:12])));
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  task automatic check_out(input string t, input logic [15:0] exp);
    chk(t, 32'(dac_code), 32'(exp));
    chk({t, "_R11"}, 32'(ladder), 32'(exp[11:0]));
    chk({t, "_R10"}, 32'(seg_en), 32'(exp_seg(int'(exp[15:12]))));
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sched(input logic [15:0] v);
    pend = 1; pend_val = v; pend_due = cyc + LAT;
  endtask

  task automatic set_cs(input logic v);
    @(negedge clk); #1;
    if (v && !sel_n && load_n == 1'b0 && clr_n) sched(m_sh);
    sel_n = v;
    gap(4);
  endtask

  task automatic set_ld(input logic v);
    @(negedge clk); #1;
    if (!v && load_n && clr_n) sched(m_sh);
    load_n = v;
    gap(4);
  endtask

  task automatic set_clr(input logic v);
    @(negedge clk); #1;
    if (!v && clr_n) begin m_sh = '0; sched('0); end
    clr_n = v;
    gap(4);
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk); #1; sdi = b; gap(4);
    @(negedge clk); #1; sclk = 1'b1;
    if (!sel_n) m_sh = {m_sh[14:0], b};
    gap(4);
    @(negedge clk); #1; sclk = 1'b0; gap(4);
  endtask

  // leaves sel_n low; caller ends the frame
  task automatic send(input logic [31:0] val, input int n);
    set_cs(1'b0);
    for (int i = n - 1; i >= 0; i--) bit_out(val[i]);
  endtask

  initial begin
    rst_n = 0; sel_n = 1; sclk = 0; sdi = 0; load_n = 1; clr_n = 1;
    repeat (5) @(negedge clk);
    #1 rst_n = 1;
    gap(3);
    tag = "R1"; check_out("R1_reset", 16'h0000);

    // R4 then R5: frame ends with load high, later strobe
    tag = "R4"; send(32'h3C96, 16); set_cs(1'b1); gap(4);
    check_out("R4_no_xfer", 16'h0000);
    tag = "R5"; set_ld(1'b0); gap(2);
    check_out("R5_strobe_R2", 16'h3C96);

    // R3: load held low at end of frame
    tag = "R3"; send(32'hA5C3, 16); set_cs(1'b1); gap(2);
    check_out("R3_end_frame", 16'hA5C3);
    set_ld(1'b1);

    // R7: sclk with select high is ignored
    tag = "R7";
    for (int i = 0; i < 16; i++) bit_out(1'b1);
    set_ld(1'b0); gap(2);
    check_out("R7_cs_high_ignored", 16'hA5C3);
    set_ld(1'b1);

    // R6: long and short frames
    tag = "R6"; send(32'h9_8765, 20); set_cs(1'b1); set_ld(1'b0); gap(2);
    check_out("R6_long_frame", 16'h8765);
    set_ld(1'b1);
    send(32'h4E, 8); set_cs(1'b1); set_ld(1'b0); gap(2);
    check_out("R6_short_frame", 16'h654E);

    // R10: sweep of the upper nibble, load held low
    tag = "R10";
    for (int k = 0; k < 16; k++) begin
      logic [15:0] w;
      w = {4'(k), 12'(k * 273 + 5)};
      send(32'(w), 16); set_cs(1'b1); gap(2);
      check_out("R10_sweep", w);
    end
    set_ld(1'b1);

    // R8 / R9: clear and masking
    tag = "R8"; set_clr(1'b0); gap(2);
    check_out("R8_clear", 16'h0000);
    tag = "R9"; send(32'h1357, 16); set_cs(1'b1);
    set_ld(1'b0); gap(2);
    check_out("R9_strobe_masked", 16'h0000);
    set_ld(1'b1);
    set_ld(1'b0);
    send(32'h2468, 16); set_cs(1'b1); gap(2);
    check_out("R9_frame_masked", 16'h0000);
    set_ld(1'b1);
    set_clr(1'b1);
    tag = "R5"; set_ld(1'b0); gap(2);
    check_out("R5_after_unmask", 16'h2468);
    set_ld(1'b1);
    tag = "R8"; set_clr(1'b0); set_clr(1'b1);
    set_ld(1'b0); gap(2);
    check_out("R8_serial_cleared", 16'h0000);
    set_ld(1'b1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule